// File: doc/BRIEF.md
# Enhanced parallel port host cycle engine

This block is the host side of an enhanced parallel port link. A processor starts one of four transfers by pulsing a start input with a two-bit kind code and, for writes, a byte. The kinds are address write, address read, data write and data read. The engine then drives an 8-bit bidirectional data bus, a Write direction line and one of two active-low strobes, one for address and one for data. It paces the whole transfer on the device's Wait level and has no fixed timing. For reads it keeps the byte that the device returned.

The device's Wait and interrupt inputs each pass through a two-flop synchronizer. A rising interrupt edge sets a sticky pending flag. The device does not report interrupt causes on extra pins, so software reads them back with ordinary address and data cycles. A programmable watchdog aborts any transfer whose Wait level stalls. An active-low device reset output belongs to software alone: a system reset only ever leaves it inactive and never pulses the device.

Top module: `epp_host_ctrl`

## Requirements
- R1: After system reset both strobes are high, Write is high, the data bus driver is off, busy, timeout and interrupt-pending are low, and the device reset pin is high.
- R2: Kind bit 1 selects the strobe: 1 means the address strobe, 0 means the data strobe. Exactly one strobe falls per transfer, and the two strobes are never low together.
- R3: Kind bit 0 selects the direction: 0 is a write and drives Write low, 1 is a read and leaves Write high. On a write the host drives the byte with the output enable on before the strobe falls, and holds it until the strobe rises.
- R4: A strobe may only fall while the synchronized Wait is low. While Wait stays high the transfer waits, busy and with both strobes high.
- R5: On a read, the bus byte is captured into the read register when the synchronized Wait is seen high, before the strobe is released.
- R6: Busy rises on the clock edge that accepts start. It stays high until the strobe is released and the synchronized Wait has returned low. A start that arrives while busy is ignored.
- R7: If Wait does not change within tmo_limit consecutive clocks of any waiting phase, the transfer is aborted. Both strobes go high, busy drops, and a timeout flag is set that stays set until tmo_clr.
- R8: A rising edge on the interrupt input sets irq_pending on the third clock edge after it. The flag stays set until irq_clr. A level that stays high does not set it again.
- R9: The device reset pin goes low on the edge after a write with rst_val=1, goes high on the edge after a write with rst_val=0, and holds otherwise. System reset forces it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| start | input | 1 | Pulse that requests a transfer |
| kind | input | 2 | Bit 1: address(1)/data(0); bit 0: read(1)/write(0) |
| wr_byte | input | 8 | Byte to send on a write |
| tmo_limit | input | 16 | Watchdog length in clocks per waiting phase |
| tmo_clr | input | 1 | Clears the timeout flag |
| irq_clr | input | 1 | Clears the interrupt-pending flag |
| rst_wr | input | 1 | Write strobe for the device reset control |
| rst_val | input | 1 | 1 asserts the device reset, 0 releases it |
| rd_byte | output | 8 | Last byte captured by a read |
| busy | output | 1 | Transfer in progress |
| tmo_flag | output | 1 | Sticky watchdog abort flag |
| irq_pending | output | 1 | Sticky device interrupt flag |
| pp_data_o | output | 8 | Data bus output value |
| pp_data_oe | output | 1 | Data bus output enable |
| pp_data_i | input | 8 | Data bus input value |
| pp_write | output | 1 | Direction line, low for writes |
| pp_astrb_n | output | 1 | Active-low address strobe |
| pp_dstrb_n | output | 1 | Active-low data strobe |
| pp_wait | input | 1 | Device Wait handshake |
| pp_intr | input | 1 | Device interrupt |
| pp_devrst_n | output | 1 | Active-low device reset |

## Verification
Busy and the device reset pin are registered, so they change on the first clock edge after their request. The bench drives requests at a falling edge and samples at the next falling edge. The interrupt flag comes after two synchronizer stages and one edge stage, so the bench samples it two falling edges after the input rises, expecting it low, and again one edge later, expecting it high. Strobe and Wait timing depends on the device model's delays plus the two-flop synchronizer, so those results are checked once busy drops, inside a bounded polling window, with the strobe-time values recorded by the model.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ARM  = 2'd1,
    PH_STRB = 2'd2,
    PH_REL  = 2'd3
  } epp_phase_t;

  localparam int KIND_READ_BIT = 0;
  localparam int KIND_ADDR_BIT = 1;
endpackage

// File: rtl/epp_sync2.sv
module epp_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        sync_q <= meta_q;
      end
    end
    assign sync_o[b] = sync_q;
  end
endmodule

// File: rtl/epp_irq_latch.sv
module epp_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic intr_s,
  input  logic irq_clr,
  output logic irq_pending
);
  logic prev_q;
  logic pend_q;
  logic pend_d;
  logic rise;

  assign rise = intr_s & ~prev_q;

  always_comb begin
    pend_d = pend_q;
    if (irq_clr) pend_d = 1'b0;
    if (rise)    pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= intr_s;
      pend_q <= pend_d;
    end
  end

  assign irq_pending = pend_q;

  AST_IRQ_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_s) |=> irq_pending); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_clr) |=> irq_pending); // R8
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_host_pkg::*;
#(
  parameter int DW    = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       kind,
  input  logic [DW-1:0]    wr_byte,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             tmo_clr,
  input  logic             wait_s,
  input  logic [DW-1:0]    bus_i,
  output logic [DW-1:0]    bus_o,
  output logic             bus_oe,
  output logic             write_o,
  output logic             astrb_n,
  output logic             dstrb_n,
  output logic [DW-1:0]    rd_byte,
  output logic             busy,
  output logic             tmo_flag
);
  epp_phase_t       phase_q, phase_d;
  logic [1:0]       kind_q, kind_d;
  logic [DW-1:0]    wb_q, wb_d;
  logic [DW-1:0]    rd_q, rd_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             tmo_q, tmo_d;
  logic [TMO_W-1:0] tick;
  logic             expired;
  logic             strobe_on;

  assign tick    = cnt_q + 1'b1;
  assign expired = (tick == tmo_limit);

  always_comb begin
    phase_d = phase_q;
    kind_d  = kind_q;
    wb_d    = wb_q;
    rd_d    = rd_q;
    cnt_d   = '0;
    tmo_d   = tmo_clr ? 1'b0 : tmo_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          kind_d  = kind;
          wb_d    = wr_byte;
          phase_d = PH_ARM;
        end
      end
      PH_ARM: begin
        if (!wait_s) phase_d = PH_STRB;
        else if (expired) begin
          phase_d = PH_IDLE;
          tmo_d   = 1'b1;
        end else cnt_d = tick;
      end
      PH_STRB: begin
        if (wait_s) begin
          phase_d = PH_REL;
          if (kind_q[KIND_READ_BIT]) rd_d = bus_i;
        end else if (expired) begin
          phase_d = PH_IDLE;
          tmo_d   = 1'b1;
        end else cnt_d = tick;
      end
      PH_REL: begin
        if (!wait_s) phase_d = PH_IDLE;
        else if (expired) begin
          phase_d = PH_IDLE;
          tmo_d   = 1'b1;
        end else cnt_d = tick;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kind_q  <= 2'b00;
      wb_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      tmo_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      kind_q  <= kind_d;
      wb_q    <= wb_d;
      rd_q    <= rd_d;
      cnt_q   <= cnt_d;
      tmo_q   <= tmo_d;
    end
  end

  assign strobe_on = (phase_q == PH_STRB);
  assign astrb_n   = ~(strobe_on & kind_q[KIND_ADDR_BIT]);
  assign dstrb_n   = ~(strobe_on & ~kind_q[KIND_ADDR_BIT]);
  assign write_o   = (phase_q == PH_IDLE) ? 1'b1 : kind_q[KIND_READ_BIT];
  assign bus_oe    = (phase_q != PH_IDLE) & ~kind_q[KIND_READ_BIT];
  assign bus_o     = wb_q;
  assign busy      = (phase_q != PH_IDLE);
  assign rd_byte   = rd_q;
  assign tmo_flag  = tmo_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!astrb_n && !dstrb_n)); // R2
  AST_STROBE_AFTER_WAIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(astrb_n) || $fell(dstrb_n)) |-> $past(!wait_s)); // R4
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_o)); // R3
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R6
  AST_TMO_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> (astrb_n && dstrb_n && !busy)); // R7
endmodule

// File: rtl/epp_host_ctrl.sv
module epp_host_ctrl #(
  parameter int DW    = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       kind,
  input  logic [DW-1:0]    wr_byte,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             tmo_clr,
  input  logic             irq_clr,
  input  logic             rst_wr,
  input  logic             rst_val,
  output logic [DW-1:0]    rd_byte,
  output logic             busy,
  output logic             tmo_flag,
  output logic             irq_pending,
  output logic [DW-1:0]    pp_data_o,
  output logic             pp_data_oe,
  input  logic [DW-1:0]    pp_data_i,
  output logic             pp_write,
  output logic             pp_astrb_n,
  output logic             pp_dstrb_n,
  input  logic             pp_wait,
  input  logic             pp_intr,
  output logic             pp_devrst_n
);
  localparam int NSYNC = 2;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] sync_in;
  logic             devrst_q, devrst_d;

  assign raw_in = {pp_intr, pp_wait};

  epp_sync2 #(.WIDTH(NSYNC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_in),
    .sync_o  (sync_in)
  );

  epp_cycle_fsm #(.DW(DW), .TMO_W(TMO_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .kind      (kind),
    .wr_byte   (wr_byte),
    .tmo_limit (tmo_limit),
    .tmo_clr   (tmo_clr),
    .wait_s    (sync_in[0]),
    .bus_i     (pp_data_i),
    .bus_o     (pp_data_o),
    .bus_oe    (pp_data_oe),
    .write_o   (pp_write),
    .astrb_n   (pp_astrb_n),
    .dstrb_n   (pp_dstrb_n),
    .rd_byte   (rd_byte),
    .busy      (busy),
    .tmo_flag  (tmo_flag)
  );

  epp_irq_latch u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .intr_s      (sync_in[1]),
    .irq_clr     (irq_clr),
    .irq_pending (irq_pending)
  );

  always_comb begin
    devrst_d = devrst_q;
    if (rst_wr) devrst_d = ~rst_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) devrst_q <= 1'b1;
    else        devrst_q <= devrst_d;
  end

  assign pp_devrst_n = devrst_q;

  AST_DEVRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_wr |=> $stable(pp_devrst_n)); // R9
  AST_DEVRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> (pp_devrst_n == !$past(rst_val))); // R9
endmodule

// File: tb/epp_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module epp_host_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [1:0]  kind;
  logic [7:0]  wr_byte;
  logic [15:0] tmo_limit;
  logic        tmo_clr, irq_clr, rst_wr, rst_val;
  logic [7:0]  rd_byte;
  logic        busy, tmo_flag, irq_pending;
  logic [7:0]  pp_data_o;
  logic        pp_data_oe;
  logic [7:0]  pp_data_i;
  logic        pp_write, pp_astrb_n, pp_dstrb_n;
  logic        pp_wait, pp_intr, pp_devrst_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  // device model state
  bit         m_en;
  logic       m_wait;
  logic       man_wait;
  int         m_dly_hi, m_dly_lo, m_cnt;
  logic [7:0] m_rdata;
  int         m_nstrb, m_overlap;
  logic       m_prev_low;
  logic       m_saw_addr, m_saw_write, m_saw_oe;
  logic [7:0] m_saw_data, m_end_data;

  assign pp_wait   = m_en ? m_wait : man_wait;
  assign pp_data_i = m_rdata;

  epp_host_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .wr_byte(wr_byte),
    .tmo_limit(tmo_limit), .tmo_clr(tmo_clr), .irq_clr(irq_clr),
    .rst_wr(rst_wr), .rst_val(rst_val), .rd_byte(rd_byte), .busy(busy),
    .tmo_flag(tmo_flag), .irq_pending(irq_pending), .pp_data_o(pp_data_o),
    .pp_data_oe(pp_data_oe), .pp_data_i(pp_data_i), .pp_write(pp_write),
    .pp_astrb_n(pp_astrb_n), .pp_dstrb_n(pp_dstrb_n), .pp_wait(pp_wait),
    .pp_intr(pp_intr), .pp_devrst_n(pp_devrst_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    logic low;
    low = !pp_astrb_n || !pp_dstrb_n;
    if (!pp_astrb_n && !pp_dstrb_n) m_overlap++;
    if (low && !m_prev_low) begin
      m_nstrb++;
      m_saw_addr  = !pp_astrb_n;
      m_saw_write = pp_write;
      m_saw_data  = pp_data_o;
      m_saw_oe    = pp_data_oe;
    end
    m_prev_low = low;
    if (m_en) begin
      if (low && !m_wait) begin
        m_cnt++;
        if (m_cnt >= m_dly_hi) begin
          m_wait = 1'b1; m_cnt = 0; m_end_data = pp_data_o;
        end
      end else if (!low && m_wait) begin
        m_cnt++;
        if (m_cnt >= m_dly_lo) begin
          m_wait = 1'b0; m_cnt = 0;
        end
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle(output bit ok);
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) begin ok = 1; break; end
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [7:0] b);
    @(negedge clk);
    start = 1'b1; kind = k; wr_byte = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R1", "astrb_n", pp_astrb_n, 1);
    chk("R1", "dstrb_n", pp_dstrb_n, 1);
    chk("R1", "write", pp_write, 1);
    chk("R1", "oe", pp_data_oe, 0);
    chk("R1", "busy/tmo/irq", {busy, tmo_flag, irq_pending}, 0);
    chk("R1", "devrst_n", pp_devrst_n, 1);
  endtask

  task automatic t_write(input logic [1:0] k, input logic [7:0] b);
    int n0; bit ok;
    n0 = m_nstrb;
    @(negedge clk);
    start = 1'b1; kind = k; wr_byte = b;
    @(negedge clk);
    start = 1'b0;
    chk("R6", "busy after start", busy, 1);
    wait_idle(ok);
    chk("R6", "write finished", ok, 1);
    chk("R2", "one strobe", m_nstrb - n0, 1);
    chk("R2", "strobe kind", m_saw_addr, k[1]);
    chk("R3", "write line low", m_saw_write, 0);
    chk("R3", "oe at strobe", m_saw_oe, 1);
    chk("R3", "data at strobe", m_saw_data, b);
    chk("R3", "data at wait", m_end_data, b);
  endtask

  task automatic t_read(input logic [1:0] k, input logic [7:0] b);
    int n0; bit ok;
    n0 = m_nstrb;
    m_rdata = b;
    issue(k, 8'h00);
    wait_idle(ok);
    chk("R6", "read finished", ok, 1);
    chk("R2", "one strobe", m_nstrb - n0, 1);
    chk("R2", "strobe kind", m_saw_addr, k[1]);
    chk("R3", "write line high", m_saw_write, 1);
    chk("R3", "oe off on read", m_saw_oe, 0);
    chk("R5", "read byte", rd_byte, b);
  endtask

  task automatic t_wait_gate;
    bit ok;
    m_en = 0; man_wait = 1'b1;
    issue(2'b00, 8'h77);
    cycles(8);
    chk("R4", "strobes held while wait high", {pp_astrb_n, pp_dstrb_n}, 2'b11);
    chk("R4", "busy while gated", busy, 1);
    man_wait = 1'b0;
    cycles(4);
    chk("R4", "data strobe after wait low", pp_dstrb_n, 0);
    man_wait = 1'b1;
    cycles(5);
    man_wait = 1'b0;
    wait_idle(ok);
    chk("R4", "gated cycle finished", ok, 1);
    m_en = 1;
  endtask

  task automatic t_busy_hold;
    bit ok;
    m_dly_lo = 12;
    issue(2'b00, 8'h42);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!pp_dstrb_n) break;
    end
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pp_dstrb_n) break;
    end
    cycles(3);
    chk("R6", "busy while wait still high", busy, 1);
    wait_idle(ok);
    chk("R6", "busy drops after wait low", ok, 1);
    m_dly_lo = 2;
  endtask

  task automatic t_ignored_start;
    int n0; bit ok;
    n0 = m_nstrb;
    issue(2'b00, 8'h11);
    start = 1'b1; kind = 2'b10; wr_byte = 8'h22;
    @(negedge clk);
    start = 1'b0;
    wait_idle(ok);
    cycles(6);
    chk("R6", "start while busy ignored: strobes", m_nstrb - n0, 1);
    chk("R6", "start while busy ignored: data", m_saw_data, 8'h11);
    chk("R6", "start while busy ignored: kind", m_saw_addr, 0);
  endtask

  task automatic t_timeout;
    bit ok;
    m_en = 0; man_wait = 1'b0;
    tmo_limit = 16'd6;
    issue(2'b01, 8'h00);
    cycles(3);
    chk("R7", "busy before limit", busy, 1);
    wait_idle(ok);
    chk("R7", "aborted", ok, 1);
    chk("R7", "tmo flag", tmo_flag, 1);
    chk("R7", "strobes released", {pp_astrb_n, pp_dstrb_n}, 2'b11);
    cycles(3);
    chk("R7", "tmo flag sticky", tmo_flag, 1);
    tmo_clr = 1'b1;
    @(negedge clk);
    tmo_clr = 1'b0;
    chk("R7", "tmo cleared", tmo_flag, 0);
    tmo_limit = 16'd1000;
    m_en = 1;
  endtask

  task automatic t_irq;
    pp_intr = 1'b1;
    cycles(2);
    chk("R8", "pending not yet", irq_pending, 0);
    cycles(1);
    chk("R8", "pending on third edge", irq_pending, 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    cycles(4);
    chk("R8", "high level no re-set", irq_pending, 0);
    pp_intr = 1'b0;
    cycles(4);
    pp_intr = 1'b1;
    cycles(4);
    chk("R8", "second edge sets", irq_pending, 1);
  endtask

  task automatic t_devrst;
    rst_wr = 1'b1; rst_val = 1'b1;
    @(negedge clk);
    rst_wr = 1'b0;
    chk("R9", "devrst asserted", pp_devrst_n, 0);
    cycles(5);
    chk("R9", "devrst holds", pp_devrst_n, 0);
    rst_wr = 1'b1; rst_val = 1'b0;
    @(negedge clk);
    rst_wr = 1'b0;
    chk("R9", "devrst released", pp_devrst_n, 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; kind = 2'b00; wr_byte = 8'h00;
    tmo_limit = 16'd1000; tmo_clr = 1'b0; irq_clr = 1'b0;
    rst_wr = 1'b0; rst_val = 1'b0; pp_intr = 1'b0;
    m_en = 1; m_wait = 1'b0; man_wait = 1'b0; m_dly_hi = 3; m_dly_lo = 2;
    m_cnt = 0; m_rdata = 8'h00; m_nstrb = 0; m_overlap = 0; m_prev_low = 1'b0;
    m_saw_addr = 0; m_saw_write = 1; m_saw_oe = 0; m_saw_data = 0; m_end_data = 0;
    cycles(3);
    t_reset_state();
    rst_n = 1'b1;
    cycles(2);
    t_write(2'b10, 8'hA5);
    t_write(2'b00, 8'h5A);
    t_read(2'b01, 8'h3C);
    t_read(2'b11, 8'hC3);
    t_wait_gate();
    t_busy_hold();
    t_ignored_start();
    t_timeout();
    t_irq();
    t_devrst();
    chk("R2", "strobes never overlapped", m_overlap, 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule